// File: doc/BRIEF.md
# Delta-Sigma ADC Conversion Readout Controller

This controller runs single conversions on an external 24-bit delta-sigma converter. It talks to the converter over a four-wire serial bus and watches the converter's active-low data-ready line. For each conversion it raises a start pin and waits for data-ready to fall. It then reads the result at once, so the read never falls inside the window just before the next data-ready edge. It returns the 24-bit two's complement sample with a one-cycle strobe.

The converter wakes up in continuous-read mode. In that mode, clocking the bus returns conversion data, so no command byte is needed to read a result. Register commands only work once continuous reading has been stopped. The controller therefore tracks the converter's mode. It prepends a stop-continuous command to the first register access. In stopped mode, it sends a read-data command before each result read. Any reset, whether of the controller or of the converter's reset pin, returns the tracked mode to continuous-read.

An optional trailing checksum byte can be checked. In that check the top bit of the byte may carry an out-of-range flag in place of a sum bit. If data-ready does not fall within a programmable number of cycles, the controller:
- flags a timeout,
- drops the start pin,
- holds the serial clock low long enough to reset the converter's serial port,
- then returns to idle.

Top module: `adc_readout_ctrl`

## Requirements
- R1: Out of reset the tracked mode is continuous-read. `adc_cs_n`=1, `adc_sclk`=0, `adc_start`=0 and `adc_rst_n`=1. `busy` stays high for exactly WAKE_CYC cycles and then falls.
- R2: A register access (`reg_req`) sends `reg_cmd` then `reg_arg` in one chip-select window. If the tracked mode is continuous-read, the stop-continuous opcode 0x11 is sent first in the same window and the mode becomes stopped. Later accesses send only the two bytes. `reg_done` pulses at the end.
- R3: Bus framing: SCLK idles low and is only active while `adc_cs_n` is low. Bytes go MSB first. MOSI changes with the SCLK rising edge and MISO is sampled on the falling edge. SCLK stays high, and stays low, for SCLK_HALF clock cycles per phase.
- R4: `start_req` raises `adc_start`. It stays high with no toggle until a falling edge of the synchronized `adc_drdy` is seen, or until a timeout occurs. Then it drops.
- R5: After the falling edge, the controller reads 3 bytes, or 4 when `chk_en`=1, while sending 0x00. In continuous-read mode no command byte comes first. In stopped mode the read-data opcode 0x12 is sent first and the byte returned during it is discarded.
- R6: `sample` holds the first three bytes read, with the first byte as bits 23:16. `sample_valid` is a one-cycle strobe.
- R7: With `chk_en`=1 and `ovr_en`=0, `chk_ok`=1 exactly when the fourth byte equals (byte1+byte2+byte3+0x9B) mod 256. With `chk_en`=0, `chk_ok`=1 and `over_range`=0.
- R8: With `chk_en`=1 and `ovr_en`=1, `over_range` is bit 7 of the fourth byte. `chk_ok` compares only bits 6:0 of the byte with bits 6:0 of that sum.
- R9: If data-ready has not fallen when the wait counter reaches `tmo_lim`, `tmo_err` pulses for one cycle and `adc_start` drops. SCLK is then held low, with `adc_cs_n` low, for RECOV_CYC cycles, during which `busy` stays high. No `sample_valid` is given.
- R10: `rst_req` drives `adc_rst_n` low for RST_LO_CYC cycles. The controller then stays busy for WAKE_CYC cycles. The tracked mode returns to continuous-read, so the next result read has no command byte.
- R11: `start_req`, `reg_req` and `rst_req` are ignored while `busy` is high. Priority when idle is `rst_req`, then `reg_req`, then `start_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, counted as converter clock cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request one conversion and readout |
| reg_req | input | 1 | Request a two-byte register command |
| rst_req | input | 1 | Request a converter reset-pin pulse |
| reg_cmd | input | 8 | Register command byte |
| reg_arg | input | 8 | Register argument byte |
| chk_en | input | 1 | Read and check the trailing checksum byte |
| ovr_en | input | 1 | Checksum bit 7 carries the out-of-range flag |
| tmo_lim | input | TMO_W | Data-ready wait limit in cycles |
| busy | output | 1 | Controller not idle |
| sample | output | 24 | Last conversion result, two's complement |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| chk_ok | output | 1 | Checksum of the last sample matched |
| over_range | output | 1 | Out-of-range flag of the last sample |
| tmo_err | output | 1 | One-cycle strobe on data-ready timeout |
| reg_done | output | 1 | One-cycle strobe at register access end |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_mosi | output | 1 | Serial data to converter |
| adc_miso | input | 1 | Serial data from converter |
| adc_start | output | 1 | Converter start pin |
| adc_rst_n | output | 1 | Converter reset pin, active low |
| adc_drdy | input | 1 | Converter data-ready, active low, asynchronous |

## Verification
The readout is swept over eight data words in both tracked modes and three checksum settings. The data words are:
- all ones,
- the most negative value,
- zero,
- the most positive value,
- computed mixtures.

The result and the bytes seen on MOSI separate the two read framings. The checksum byte is written correct, corrupted in a low bit, and, with the flag enabled, with a bit 7 that disagrees with the sum. This separates a full-byte compare from a 7-bit compare and shows where the flag is taken from.

A data-ready line that never falls exercises the timeout and the held-low recovery window. Register accesses before and after a stop separate first-access framing from later framing. Requests pulsed while busy must leave no trace on the bus.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam logic [7:0] OP_STOPC = 8'h11;
  localparam logic [7:0] OP_RDATA = 8'h12;
  localparam logic [7:0] CHK_SEED = 8'h9B;

  typedef enum logic [3:0] {
    ST_WAKE,
    ST_IDLE,
    ST_RSTLO,
    ST_STOPC,
    ST_REGC,
    ST_REGA,
    ST_CONV,
    ST_RDCMD,
    ST_RDBYTE,
    ST_DONE,
    ST_RECOV
  } ctl_st_t;

  // Byte sum of the three data bytes plus the seed, carry dropped.
  function automatic logic [7:0] chk_sum(input logic [23:0] w);
    logic [7:0] s;
    s = w[23:16] + w[15:8] + w[7:0] + CHK_SEED;
    return s;
  endfunction

  // With the flag in use, bit 7 is excluded from the compare.
  function automatic logic chk_match(input logic [7:0] cb, input logic [23:0] w,
                                     input logic flag_mode);
    logic [7:0] s;
    s = chk_sum(w);
    if (flag_mode) return cb[6:0] == s[6:0];
    return cb == s;
  endfunction

endpackage

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_in,
  output logic fall
);
  logic [SYNC_N:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_N-1:0], drdy_in};
  end

  // Falling edge seen on the synchronized copy.
  assign fall = chain[SYNC_N] & ~chain[SYNC_N-1];
endmodule

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);

  logic            act, hi;
  logic [PH_W-1:0] ph;
  logic [2:0]      bitc;
  logic [7:0]      tsh, rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; hi <= 1'b0; ph <= '0; bitc <= '0;
      tsh <= '0; rsh <= '0; sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (go) begin
          act  <= 1'b1; hi <= 1'b1; ph <= '0; bitc <= '0;
          sclk <= 1'b1;
          mosi <= tx[7];
          tsh  <= {tx[6:0], 1'b0};
        end
      end else if (ph == PH_LAST) begin
        ph <= '0;
        if (hi) begin
          sclk <= 1'b0;
          hi   <= 1'b0;
          rsh  <= {rsh[6:0], miso};
        end else if (bitc == 3'd7) begin
          act  <= 1'b0;
          done <= 1'b1;
          mosi <= 1'b0;
        end else begin
          bitc <= bitc + 3'd1;
          sclk <= 1'b1;
          hi   <= 1'b1;
          mosi <= tsh[7];
          tsh  <= {tsh[6:0], 1'b0};
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign busy = act;
  assign rx   = rsh;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int SYNC_N     = 2,
  parameter int WAKE_CYC   = 8,
  parameter int RST_LO_CYC = 4,
  parameter int RECOV_CYC  = 65536,
  parameter int TMO_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             reg_req,
  input  logic             rst_req,
  input  logic [7:0]       reg_cmd,
  input  logic [7:0]       reg_arg,
  input  logic             chk_en,
  input  logic             ovr_en,
  input  logic [TMO_W-1:0] tmo_lim,
  output logic             busy,
  output logic [23:0]      sample,
  output logic             sample_valid,
  output logic             chk_ok,
  output logic             over_range,
  output logic             tmo_err,
  output logic             reg_done,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso,
  output logic             adc_start,
  output logic             adc_rst_n,
  input  logic             adc_drdy
);
  localparam int MAX_A = (WAKE_CYC > RST_LO_CYC) ? WAKE_CYC : RST_LO_CYC;
  localparam int MAX_C = (RECOV_CYC > MAX_A) ? RECOV_CYC : MAX_A;
  localparam int WC_W  = $clog2(MAX_C + 1);

  ctl_st_t          st;
  logic             mode_cont, xsent, chk_l, ovr_l;
  logic [WC_W-1:0]  wcnt;
  logic [TMO_W-1:0] tcnt;
  logic [2:0]       bcnt;
  logic [31:0]      word_q;
  logic [7:0]       cmd_l, arg_l, tx_byte;

  // Named internal events, also observed by the checker.
  logic       drdy_fall, xfer_st, xfer_go, xfer_done, xfer_busy, tmo_hit, last_byte;
  logic [7:0] rx_byte;
  logic [2:0] nbytes;

  adc_drdy_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .drdy_in(adc_drdy), .fall(drdy_fall)
  );

  adc_spi_byte #(.HALF(SCLK_HALF)) u_byte (
    .clk(clk), .rst_n(rst_n), .go(xfer_go), .tx(tx_byte), .miso(adc_miso),
    .sclk(adc_sclk), .mosi(adc_mosi), .busy(xfer_busy), .done(xfer_done),
    .rx(rx_byte)
  );

  always_comb begin
    xfer_st = (st == ST_STOPC) || (st == ST_REGC) || (st == ST_REGA) ||
              (st == ST_RDCMD) || (st == ST_RDBYTE);
    xfer_go = xfer_st && !xsent;
    case (st)
      ST_STOPC: tx_byte = OP_STOPC;
      ST_REGC:  tx_byte = cmd_l;
      ST_REGA:  tx_byte = arg_l;
      ST_RDCMD: tx_byte = OP_RDATA;
      default:  tx_byte = 8'h00;
    endcase
    nbytes    = chk_l ? 3'd4 : 3'd3;
    last_byte = (bcnt == nbytes - 3'd1);
    tmo_hit   = (st == ST_CONV) && !drdy_fall && (tcnt == tmo_lim);
  end

  assign busy      = (st != ST_IDLE);
  assign adc_cs_n  = !(xfer_st || st == ST_RECOV);
  assign adc_start = (st == ST_CONV);
  assign adc_rst_n = (st != ST_RSTLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_WAKE; mode_cont <= 1'b1; xsent <= 1'b0;
      wcnt <= '0; tcnt <= '0; bcnt <= '0; word_q <= '0;
      chk_l <= 1'b0; ovr_l <= 1'b0; cmd_l <= '0; arg_l <= '0;
      sample <= '0; sample_valid <= 1'b0; chk_ok <= 1'b0; over_range <= 1'b0;
      tmo_err <= 1'b0; reg_done <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      tmo_err      <= 1'b0;
      reg_done     <= 1'b0;
      if (xfer_done)    xsent <= 1'b0;
      else if (xfer_go) xsent <= 1'b1;

      case (st)
        ST_WAKE: begin
          if (wcnt == WC_W'(WAKE_CYC - 1)) begin wcnt <= '0; st <= ST_IDLE; end
          else wcnt <= wcnt + 1'b1;
        end
        ST_IDLE: begin
          if (rst_req) begin
            mode_cont <= 1'b1; wcnt <= '0; st <= ST_RSTLO;
          end else if (reg_req) begin
            cmd_l <= reg_cmd; arg_l <= reg_arg;
            st    <= mode_cont ? ST_STOPC : ST_REGC;
          end else if (start_req) begin
            chk_l <= chk_en; ovr_l <= ovr_en;
            tcnt  <= '0; bcnt <= '0; st <= ST_CONV;
          end
        end
        ST_RSTLO: begin
          if (wcnt == WC_W'(RST_LO_CYC - 1)) begin wcnt <= '0; st <= ST_WAKE; end
          else wcnt <= wcnt + 1'b1;
        end
        ST_STOPC: if (xfer_done) begin mode_cont <= 1'b0; st <= ST_REGC; end
        ST_REGC:  if (xfer_done) st <= ST_REGA;
        ST_REGA:  if (xfer_done) begin reg_done <= 1'b1; st <= ST_IDLE; end
        ST_CONV: begin
          if (drdy_fall)      st <= mode_cont ? ST_RDBYTE : ST_RDCMD;
          else if (tmo_hit) begin tmo_err <= 1'b1; wcnt <= '0; st <= ST_RECOV; end
          else                tcnt <= tcnt + 1'b1;
        end
        ST_RDCMD: if (xfer_done) st <= ST_RDBYTE;
        ST_RDBYTE: begin
          if (xfer_done) begin
            word_q <= {word_q[23:0], rx_byte};
            if (last_byte) st <= ST_DONE;
            else           bcnt <= bcnt + 3'd1;
          end
        end
        ST_DONE: begin
          sample       <= chk_l ? word_q[31:8] : word_q[23:0];
          chk_ok       <= chk_l ? chk_match(word_q[7:0], word_q[31:8], ovr_l) : 1'b1;
          over_range   <= chk_l & ovr_l & word_q[7];
          sample_valid <= 1'b1;
          st           <= ST_IDLE;
        end
        ST_RECOV: begin
          if (wcnt == WC_W'(RECOV_CYC - 1)) begin wcnt <= '0; st <= ST_IDLE; end
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_start,
  input logic adc_rst_n,
  input logic sample_valid,
  input logic tmo_err,
  input logic mode_cont,
  input logic drdy_fall,
  input logic tmo_hit,
  input logic xfer_go,
  input logic xfer_busy
);
  p_mode_cont_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rst_n |-> mode_cont);

  p_sclk_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  p_go_only_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> !xfer_busy);

  p_start_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start) |-> ($past(drdy_fall) || $past(tmo_hit)));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  p_timeout_no_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> !sample_valid);
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_start(adc_start), .adc_rst_n(adc_rst_n), .sample_valid(sample_valid),
  .tmo_err(tmo_err), .mode_cont(mode_cont), .drdy_fall(drdy_fall),
  .tmo_hit(tmo_hit), .xfer_go(xfer_go), .xfer_busy(xfer_busy)
);

// File: tb/adc_readout_ctrl_test.sv
module adc_readout_ctrl_test;
  localparam int HALF  = 2;
  localparam int WAKE  = 8;
  localparam int RSTLO = 4;
  localparam int RECOV = 40;
  localparam int TW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, reg_req = 1'b0, rst_req = 1'b0;
  logic [7:0] reg_cmd = 8'h00, reg_arg = 8'h00;
  logic chk_en = 1'b0, ovr_en = 1'b0;
  logic [TW-1:0] tmo_lim = 16'd1000;
  logic busy, sample_valid, chk_ok, over_range, tmo_err, reg_done;
  logic [23:0] sample;
  logic adc_cs_n, adc_sclk, adc_mosi, adc_start, adc_rst_n;
  logic adc_drdy = 1'b0;
  logic miso_q = 1'b0;

  always #5 clk = ~clk;

  adc_readout_ctrl #(.SCLK_HALF(HALF), .SYNC_N(2), .WAKE_CYC(WAKE),
    .RST_LO_CYC(RSTLO), .RECOV_CYC(RECOV), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reg_req(reg_req),
    .rst_req(rst_req), .reg_cmd(reg_cmd), .reg_arg(reg_arg), .chk_en(chk_en),
    .ovr_en(ovr_en), .tmo_lim(tmo_lim), .busy(busy), .sample(sample),
    .sample_valid(sample_valid), .chk_ok(chk_ok), .over_range(over_range),
    .tmo_err(tmo_err), .reg_done(reg_done), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(miso_q),
    .adc_start(adc_start), .adc_rst_n(adc_rst_n), .adc_drdy(adc_drdy)
  );

  // Converter model: shifts a preloaded word out, logs every byte received.
  logic [39:0] m_word = 40'h0;
  int m_idx = 0;
  always @(posedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) m_idx <= 0;
    else begin
      miso_q <= (m_idx < 40) ? m_word[39 - m_idx] : 1'b0;
      m_idx  <= m_idx + 1;
    end
  end

  logic [7:0] mlog [0:1023];
  logic [7:0] m_sh = 8'h00;
  int m_bits = 0, mcnt = 0;
  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      m_sh = {m_sh[6:0], adc_mosi};
      if (m_bits == 7) begin mlog[mcnt % 1024] = m_sh; mcnt = mcnt + 1; m_bits = 0; end
      else m_bits = m_bits + 1;
    end
  end

  // SCLK phase-width monitor.
  int hi_run = 0, hi_min = 1000, hi_max = 0;
  always @(negedge clk) begin
    if (adc_sclk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit ended = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  function automatic logic [23:0] pat(input int i);
    case (i)
      0: return 24'hFFFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      3: return 24'h7FFFFF;
      default: return 24'(((i * 3083573) ^ (i << 13)) & 32'hFFFFFF);
    endcase
  endfunction

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic do_reg(input logic [7:0] c, input logic [7:0] a, input bit expect_stop);
    int base, got;
    bit seen;
    base = mcnt; seen = 1'b0;
    @(negedge clk); reg_cmd = c; reg_arg = a; reg_req = 1'b1;
    @(negedge clk); reg_req = 1'b0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      if (reg_done) seen = 1'b1; else @(negedge clk);
    end
    check(seen, "R2 reg_done", seen, 1);
    got = mcnt - base;
    if (expect_stop) begin
      check(got == 3, "R2 byte count with stop", got, 3);
      check(mlog[base % 1024] == 8'h11, "R2 stop opcode first", mlog[base % 1024], 8'h11);
      check(mlog[(base + 1) % 1024] == c && mlog[(base + 2) % 1024] == a,
            "R2 cmd/arg after stop", {mlog[(base + 1) % 1024], mlog[(base + 2) % 1024]}, {c, a});
    end else begin
      check(got == 2, "R2 byte count no stop", got, 2);
      check(mlog[base % 1024] == c && mlog[(base + 1) % 1024] == a,
            "R2 cmd/arg", {mlog[base % 1024], mlog[(base + 1) % 1024]}, {c, a});
    end
    wait_idle();
  endtask

  task automatic do_conv(input logic [23:0] d, input logic [7:0] cb, input bit ce,
                         input bit oe, input bit stopped, input bit poke);
    int base, got, nb, s;
    bit seen, zeros;
    logic [7:0] sum8;
    bit exp_ok, exp_ovr;
    m_word = stopped ? {8'hA5, d, cb} : {d, cb, 8'h5A};
    base = mcnt;
    @(negedge clk); chk_en = ce; ovr_en = oe; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    for (int k = 0; k < 10 && !adc_start; k++) @(negedge clk);
    check(adc_start == 1'b1, "R4 start pin raised", adc_start, 1);
    adc_drdy = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (poke && k == 5) begin reg_cmd = 8'h77; reg_req = 1'b1; rst_req = 1'b1; end
      if (poke && k == 6) begin reg_req = 1'b0; rst_req = 1'b0; end
      @(negedge clk);
    end
    check(adc_start == 1'b1, "R4 start pin held before edge", adc_start, 1);
    adc_drdy = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      if (sample_valid) seen = 1'b1; else @(negedge clk);
    end
    check(seen, "R6 sample strobe", seen, 1);
    check(sample == d, "R6 sample value", sample, d);
    s = (int'(d[23:16]) + int'(d[15:8]) + int'(d[7:0]) + 155) % 256;
    sum8 = 8'(s);
    if (!ce)      begin exp_ok = 1'b1; exp_ovr = 1'b0; end
    else if (!oe) begin exp_ok = (cb == sum8); exp_ovr = 1'b0; end
    else          begin exp_ok = (cb[6:0] == sum8[6:0]); exp_ovr = cb[7]; end
    check(chk_ok == exp_ok, oe ? "R8 chk_ok 7-bit" : "R7 chk_ok", chk_ok, exp_ok);
    check(over_range == exp_ovr, "R8 over_range", over_range, exp_ovr);
    check(adc_start == 1'b0, "R4 start pin dropped", adc_start, 0);
    @(negedge clk);
    check(!sample_valid, "R6 strobe one cycle", sample_valid, 0);
    wait_idle();
    repeat (4) @(negedge clk);
    nb = (stopped ? 1 : 0) + (ce ? 4 : 3);
    got = mcnt - base;
    check(got == nb, poke ? "R11 no bytes from ignored request" : "R5 read byte count", got, nb);
    if (stopped)
      check(mlog[base % 1024] == 8'h12, "R5 read opcode in stopped mode", mlog[base % 1024], 8'h12);
    zeros = 1'b1;
    for (int k = (stopped ? 1 : 0); k < got; k++)
      if (mlog[(base + k) % 1024] != 8'h00) zeros = 1'b0;
    check(zeros, "R5 data clocks send zero", zeros, 1);
  endtask

  initial begin
    int n;
    bit bad;
    logic [23:0] d;
    logic [7:0] cb;
    int s;
    repeat (3) @(negedge clk);
    check(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && adc_start == 1'b0 && adc_rst_n == 1'b1,
          "R1 pins in reset", {adc_cs_n, adc_sclk, adc_start, adc_rst_n}, 4'b1001);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 100 && busy; k++) begin n++; @(negedge clk); end
    check(n == WAKE, "R1 wake busy cycles", n, WAKE);

    // Sweep: pass 0 in continuous-read mode, pass 1 after a stop.
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin
        do_reg(8'h40, 8'h03, 1'b1);
        do_reg(8'h41, 8'h05, 1'b0);
      end
      for (int cfg = 0; cfg < 3; cfg++) begin
        for (int i = 0; i < 8; i++) begin
          d = pat(i);
          s = (int'(d[23:16]) + int'(d[15:8]) + int'(d[7:0]) + 155) % 256;
          cb = 8'(s);
          if (cfg == 2) cb[7] = cb[7] ^ i[0];
          if (i[1]) cb = cb ^ 8'h04;
          do_conv(d, cb, cfg != 0, cfg == 2, p == 1, 1'b0);
        end
      end
    end
    check(hi_min == HALF && hi_max == HALF, "R3 sclk high phase width", hi_max, HALF);

    // Requests pulsed during a conversion leave no trace on the bus.
    do_conv(24'h123456, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);

    // Timeout with data-ready stuck high.
    tmo_lim = 16'd60;
    n = mcnt;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    adc_drdy = 1'b1;
    bad = 1'b1;
    for (int k = 0; k < 500 && bad; k++) begin
      if (tmo_err) bad = 1'b0; else @(negedge clk);
    end
    check(!bad, "R9 timeout strobe", !bad, 1);
    check(adc_start == 1'b0 && adc_cs_n == 1'b0 && adc_sclk == 1'b0,
          "R9 recovery pins", {adc_start, adc_cs_n, adc_sclk}, 3'b000);
    n = 0; bad = 1'b0;
    for (int k = 0; k < 500 && busy; k++) begin
      if (adc_sclk || sample_valid) bad = 1'b1;
      n++; @(negedge clk);
    end
    check(n == RECOV, "R9 recovery length", n, RECOV);
    check(!bad, "R9 sclk low and no sample in recovery", bad, 0);
    adc_drdy = 1'b0;
    tmo_lim = 16'd1000;
    repeat (5) @(negedge clk);

    // Reset pin pulse returns mode to continuous-read.
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    n = 0;
    for (int k = 0; k < 100 && !adc_rst_n; k++) begin n++; @(negedge clk); end
    check(n == RSTLO, "R10 reset pin low cycles", n, RSTLO);
    n = 0;
    for (int k = 0; k < 100 && busy; k++) begin
      if (k == 2) start_req = 1'b1;
      if (k == 3) start_req = 1'b0;
      n++; @(negedge clk);
    end
    check(n == WAKE, "R10 wake busy after reset pin", n, WAKE);
    repeat (5) @(negedge clk);
    check(adc_start == 1'b0 && !busy, "R11 start ignored while busy", adc_start, 0);
    do_conv(24'hA1B2C3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule